// File: doc/BRIEF.md
# Read-Clocked Pseudo-Random Byte Port

This block is an 8-bit pseudo-random source inside the register window of a memory-mapped coprocessor. The host reaches it through a synchronous bus with a 7-bit offset, a read strobe and a write strobe. A read of the generator window returns the present register value on `rdData` in the same cycle. The register then takes one step at the next clock edge. An access of either kind to the clear window forces the register to zero.

The feedback is an inverted XOR of four taps. Because of this, zero is a legal state and all-ones is the lockup state. Starting from zero, the register walks through 255 distinct values and then repeats. The register only moves when its port is read, so software decides when it advances.

Top module: `rndPortTop`

## Requirements
- R1: A synchronous active-high `rst` clears the register to 0x00, so the first generator read after reset returns 0x00.
- R2: While `rdStb` is high and `busOfs` is in 0x00–0x03, `rdData` shows the register value held before that read's advance, in the same cycle.
- R3: Each read of the generator window advances the register at the next clock edge. The new value is the old value shifted left by one, with bit 0 loaded by NOT(bit7 XOR bit5 XOR bit4 XOR bit3).
- R4: All four offsets 0x00–0x03 reach the same register and advance it identically.
- R5: A read or a write at any offset 0x70–0x77 sets the register to 0x00 at the next clock edge.
- R6: Writes to the generator window, and reads or writes at offsets outside both windows, leave the register unchanged.
- R7: A read strobe held high for N consecutive cycles on the generator window counts as N reads and gives N advances.
- R8: From 0x00, the sequence never reaches 0xFF and has a period of 255, so the 256th read returns the same value as the 1st.
- R9: `rdData` is 0x00 whenever no read of the generator window is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| busOfs | input | 7 | Bus offset within the coprocessor window |
| rdStb | input | 1 | Read strobe; one access per high cycle |
| wrStb | input | 1 | Write strobe; one access per high cycle |
| rdData | output | 8 | Read data; generator value during a generator read, else zero |

## Verification
The bench builds the block with its default windows: four generator offsets starting at 0x00 and eight clear offsets starting at 0x70. With these settings, one directed run of 256 reads that rotates across all four generator offsets can show both the full 255-state period and the absence of the lockup value. Random mixes of reads and writes over both windows and the unused offsets between them also reach strobes that overlap a clear, held read strobes, and reads that leave the register untouched.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int RND_W = 8;
  localparam int OFS_W_DEF = 7;
  localparam int GEN_BASE_DEF = 'h00;
  localparam int GEN_SPAN_DEF = 4;
  localparam int CLR_BASE_DEF = 'h70;
  localparam int CLR_SPAN_DEF = 8;

  // strobes from decode to the state register
  typedef struct packed {
    logic step;   // advance one position
    logic clear;  // force to zero
    logic drive;  // put state on read data
  } rndCmd_t;
endpackage

// File: rtl/rndCtrl.sv
module rndCtrl
  import rnd_pkg::*;
#(
  parameter int OFS_W = OFS_W_DEF,
  parameter int GEN_BASE = GEN_BASE_DEF,
  parameter int GEN_SPAN = GEN_SPAN_DEF,
  parameter int CLR_BASE = CLR_BASE_DEF,
  parameter int CLR_SPAN = CLR_SPAN_DEF
) (
  input  logic [OFS_W-1:0] busOfs,
  input  logic             rdStb,
  input  logic             wrStb,
  output rndCmd_t          cmd
);
  localparam logic [OFS_W-1:0] GEN_LO = OFS_W'(GEN_BASE);
  localparam logic [OFS_W-1:0] CLR_LO = OFS_W'(CLR_BASE);
  localparam logic [OFS_W:0] GEN_N = (OFS_W+1)'(GEN_SPAN);
  localparam logic [OFS_W:0] CLR_N = (OFS_W+1)'(CLR_SPAN);

  logic [OFS_W-1:0] genRel;
  logic [OFS_W-1:0] clrRel;
  logic inGen;
  logic inClr;

  always_comb begin
    genRel = busOfs - GEN_LO;
    clrRel = busOfs - CLR_LO;
    inGen  = {1'b0, genRel} < GEN_N;
    inClr  = {1'b0, clrRel} < CLR_N;
    cmd.step  = rdStb & inGen;
    cmd.drive = rdStb & inGen;
    cmd.clear = (rdStb | wrStb) & inClr;
  end
endmodule

// File: rtl/rndPath.sv
module rndPath
  import rnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  rndCmd_t          cmd,
  output logic [RND_W-1:0] state,
  output logic [RND_W-1:0] rdData
);
  logic [RND_W-1:0] nextVal;
  logic feedBit;

  always_comb begin
    feedBit = ~(state[7] ^ state[5] ^ state[4] ^ state[3]);
    nextVal = {state[RND_W-2:0], feedBit};
    rdData  = cmd.drive ? state : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)            state <= '0;
    else if (cmd.clear) state <= '0;
    else if (cmd.step)  state <= nextVal;
  end
endmodule

// File: rtl/rndPortTop.sv
module rndPortTop
  import rnd_pkg::*;
#(
  parameter int OFS_W = OFS_W_DEF,
  parameter int GEN_BASE = GEN_BASE_DEF,
  parameter int GEN_SPAN = GEN_SPAN_DEF,
  parameter int CLR_BASE = CLR_BASE_DEF,
  parameter int CLR_SPAN = CLR_SPAN_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] busOfs,
  input  logic             rdStb,
  input  logic             wrStb,
  output logic [RND_W-1:0] rdData
);
  rndCmd_t cmd;
  logic [RND_W-1:0] genState;

  rndCtrl #(
    .OFS_W(OFS_W), .GEN_BASE(GEN_BASE), .GEN_SPAN(GEN_SPAN),
    .CLR_BASE(CLR_BASE), .CLR_SPAN(CLR_SPAN)
  ) u_ctrl (
    .busOfs(busOfs), .rdStb(rdStb), .wrStb(wrStb), .cmd(cmd)
  );

  rndPath u_path (
    .clk(clk), .rst(rst), .cmd(cmd), .state(genState), .rdData(rdData)
  );
endmodule

// File: rtl/rndPortChk.sv
module rndPortChk
  import rnd_pkg::*;
#(
  parameter int OFS_W = OFS_W_DEF,
  parameter int GEN_BASE = GEN_BASE_DEF,
  parameter int GEN_SPAN = GEN_SPAN_DEF,
  parameter int CLR_BASE = CLR_BASE_DEF,
  parameter int CLR_SPAN = CLR_SPAN_DEF
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] busOfs,
  input logic             rdStb,
  input logic             wrStb,
  input logic [RND_W-1:0] rdData,
  input logic [RND_W-1:0] genState
);
  logic genHit;
  logic clrHit;
  always_comb begin
    genHit = (int'(busOfs) >= GEN_BASE) && (int'(busOfs) < GEN_BASE + GEN_SPAN);
    clrHit = (int'(busOfs) >= CLR_BASE) && (int'(busOfs) < CLR_BASE + CLR_SPAN);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> genState == '0); // R1
  AST_READ_SHOWS_STATE: assert property (@(posedge clk) disable iff (rst)
    (rdStb && genHit) |-> rdData == genState); // R2
  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (rdStb && genHit && !clrHit) |=> genState == {$past(genState[6:0]),
      ~($past(genState[7]) ^ $past(genState[5]) ^ $past(genState[4]) ^ $past(genState[3]))}); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((rdStb || wrStb) && clrHit) |=> genState == '0); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(rdStb && genHit) && !((rdStb || wrStb) && clrHit)) |=> $stable(genState)); // R6
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    genState != 8'hFF); // R8
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
    !(rdStb && genHit) |-> rdData == '0); // R9
endmodule

bind rndPortTop rndPortChk #(
  .OFS_W(OFS_W), .GEN_BASE(GEN_BASE), .GEN_SPAN(GEN_SPAN),
  .CLR_BASE(CLR_BASE), .CLR_SPAN(CLR_SPAN)
) u_chk (
  .clk(clk), .rst(rst), .busOfs(busOfs), .rdStb(rdStb), .wrStb(wrStb),
  .rdData(rdData), .genState(genState)
);

// File: tb/tb_rndPortTop.sv
`timescale 1ns/1ps
module tb_rndPortTop;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] busOfs = '0;
  logic rdStb = 1'b0;
  logic wrStb = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;

  always #(HALF) clk = ~clk;

  rndPortTop dut (
    .clk(clk), .rst(rst), .busOfs(busOfs), .rdStb(rdStb), .wrStb(wrStb),
    .rdData(rdData)
  );

  function automatic logic [7:0] stepOf(input logic [7:0] v);
    return {v[6:0], ~(v[7] ^ v[5] ^ v[4] ^ v[3])};
  endfunction

  function automatic bit isGen(input logic [6:0] o);
    return o < 7'h04;
  endfunction

  function automatic bit isClr(input logic [6:0] o);
    return o >= 7'h70 && o <= 7'h77;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // drive one access held for n cycles, check rdData each cycle, update the model
  task automatic access(input bit rd, input bit wr, input logic [6:0] o,
                        input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rdStb = rd; wrStb = wr; busOfs = o;
      #0.5;
      check(req, rdData, (rd && isGen(o)) ? model : 8'h00);
      @(posedge clk);
      if ((rd || wr) && isClr(o)) model = '0;
      else if (rd && isGen(o)) model = stepOf(model);
    end
    @(negedge clk);
    rdStb = 1'b0; wrStb = 1'b0; busOfs = '0;
  endtask

  task automatic peek(input string req);
    access(1'b1, 1'b0, 7'h00, 1, req);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] first;
    logic [7:0] mark;
    bit sawFF;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check("R9 idle data", rdData, 8'h00);

    // R1: first read after reset is zero
    check("R1 reset value", rdData, 8'h00);
    peek("R1 first read");

    // R8 / R4: full period, rotating offsets
    access(1'b1, 1'b0, 7'h70, 1, "R5 clear via read");
    first = model;
    sawFF = 1'b0;
    for (int i = 0; i < 255; i++) begin
      if (model == 8'hFF) sawFF = 1'b1;
      access(1'b1, 1'b0, 7'(i % 4), 1, "R4 R3 sequence");
    end
    check("R8 no lockup value", {7'b0, sawFF}, 8'h00);
    mark = model;
    check("R8 256th read equals 1st", mark, first);
    peek("R8 wrap read");

    // R5: write clear
    peek("R3 advance"); peek("R3 advance");
    access(1'b0, 1'b1, 7'h77, 1, "R5 write clear");
    check("R5 model zero", model, 8'h00);
    peek("R5 read after clear");

    // R6: writes to generator, accesses elsewhere
    peek("R3 advance");
    access(1'b0, 1'b1, 7'h02, 1, "R6 write gen");
    access(1'b1, 1'b0, 7'h08, 1, "R6 R9 read other");
    access(1'b0, 1'b1, 7'h6F, 1, "R6 write other");
    access(1'b1, 1'b0, 7'h78, 1, "R6 R9 read past clear");
    peek("R6 unchanged");

    // R7: held strobe
    access(1'b1, 1'b0, 7'h03, 5, "R7 held read");
    peek("R7 after held");

    // R1: reset mid-sequence
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model = '0;
    peek("R1 reset again");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [6:0] o;
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: o = 7'($urandom % 4);
        1: o = 7'h70 + 7'($urandom % 8);
        default: o = 7'($urandom % 128);
      endcase
      access(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), o,
             1 + int'($urandom % 3), "R2 R3 R5 R6 random");
    end
    peek("R2 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule